// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block turns a fast reference clock into the pixel timing for a display panel. It produces two outputs. The first is a one-cycle enable pulse, once per pixel period. The second is a square-wave pixel clock built from reference-clock registers. The division ratio comes from two configuration fields, a low part and a high part. Joined together they hold the divisor minus two. A separate bypass bit selects divide-by-one, which the fields cannot encode.

Logic that runs on the reference clock uses the enable to advance one pixel at a time. The registered square wave can drive a panel pin. Software may rewrite the fields at any moment. The block holds the old ratio until the current pixel period has ended, so a rewrite never makes a shortened period.

Top module: `pixclk_div`

## Requirements
- R1: While `rst` is high, `pix_en` and `pix_clk` are low and the period counter is cleared. The first cycle after `rst` falls is the first cycle of a period, so with divisor N the first `pix_en` appears in the N-th cycle after release.
- R2: With bypass clear, the divisor is N = {`cfg_div_hi`, `cfg_div_lo`} + 2. `cfg_div_hi` (5 bits) supplies the upper bits and `cfg_div_lo` (5 bits) the lower bits of the 10-bit stored value.
- R3: With bypass clear, `pix_en` is high for exactly one reference cycle per period. That cycle is the last of every N cycles.
- R4: With bypass clear, `pix_clk` is low for the first ceil(N/2) cycles of each period and high for the last floor(N/2) cycles. It is therefore high in the cycle where `pix_en` pulses.
- R5: When bypass is set, `pix_en` is high in every cycle and `pix_clk` stays low. The values of both divisor fields have no effect.
- R6: The smallest divisor with bypass clear is 2, reached with both fields zero. The largest is 1025, reached with both fields all ones.
- R7: A change to bypass or to either field is captured only in the last cycle of a period. The period in progress completes at its old length, and the new setting governs the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | 1 = divide by one, fields ignored |
| cfg_div_lo | input | 5 | Lower part of divisor minus two |
| cfg_div_hi | input | 5 | Upper part of divisor minus two |
| pix_en | output | 1 | One-cycle pulse at the end of each pixel period |
| pix_clk | output | 1 | Registered square-wave pixel clock |

## Verification
A table of settings is measured in order. Each entry gives the period from one `pix_en` pulse to the next and the number of high `pix_clk` cycles. The table includes the minimum and maximum divisors, odd and even divisors (these expose rounding errors in the high phase), and a value only in the high field (this exposes a wrong field order or bit offset). Two bypass entries use different field values, so a bypass that leaks the fields shows up as a wrong period. Directed runs then change the setting partway through a long period, to tell a boundary-only reload from an immediate one. A reset in the middle of a period, followed by a release, checks that the counter restarts from zero.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

    // Offset between the stored field value and the real divisor.
    localparam int unsigned DIV_OFFSET = 2;

    // Width needed to hold the largest divisor: fields + offset.
    function automatic int unsigned div_width(input int unsigned lo_w,
                                              input int unsigned hi_w);
        return lo_w + hi_w + 1;
    endfunction

endpackage

// File: rtl/pixclk_decode.sv
module pixclk_decode #(
    parameter int unsigned LO_W = 5,
    parameter int unsigned HI_W = 5,
    parameter int unsigned NW   = pixclk_pkg::div_width(LO_W, HI_W)
) (
    input  logic            byp_i,
    input  logic [LO_W-1:0] lo_i,
    input  logic [HI_W-1:0] hi_i,
    output logic            byp_o,
    output logic [NW-1:0]   n_o
);
    logic [NW-1:0] joined;

    // High field forms the upper bits of the stored value.
    assign joined = NW'({hi_i, lo_i});
    assign n_o    = joined + NW'(pixclk_pkg::DIV_OFFSET);
    assign byp_o  = byp_i;
endmodule

// File: rtl/pixclk_counter.sv
module pixclk_counter #(
    parameter int unsigned NW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_byp,
    input  logic [NW-1:0] load_n,
    output logic          wrap,
    output logic          cur_byp,
    output logic [NW-1:0] nxt_cnt,
    output logic          nxt_byp,
    output logic [NW-1:0] nxt_n
);
    typedef struct packed {
        logic          byp;
        logic [NW-1:0] n;
    } period_t;

    period_t       cur_q, cur_d;
    logic [NW-1:0] cnt_q, cnt_d;

    always_comb begin
        wrap = cur_q.byp || (cnt_q == cur_q.n - NW'(1));
        if (wrap) begin
            cnt_d = '0;
            cur_d = '{byp: load_byp, n: load_n};
        end else begin
            cnt_d = cnt_q + NW'(1);
            cur_d = cur_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cur_q <= '{byp: load_byp, n: load_n};
        end else begin
            cnt_q <= cnt_d;
            cur_q <= cur_d;
        end
    end

    assign cur_byp = cur_q.byp;
    assign nxt_cnt = cnt_d;
    assign nxt_byp = cur_d.byp;
    assign nxt_n   = cur_d.n;

    // R1: reset leaves the counter at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    // R2: count never reaches the active divisor
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        !cur_q.byp |-> (cnt_q < cur_q.n));

    // R6: a divided period is never shorter than two cycles
    p_min_div_r6: assert property (@(posedge clk) disable iff (rst)
        !cur_q.byp |-> (cur_q.n >= NW'(2)));

    // R7: active setting only moves at a period boundary
    p_period_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cur_q));
endmodule

// File: rtl/pixclk_phase.sv
module pixclk_phase #(
    parameter int unsigned NW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] nxt_cnt,
    input  logic          nxt_byp,
    input  logic [NW-1:0] nxt_n,
    output logic          pclk_q
);
    logic [NW-1:0] low_len;

    // Low phase is the rounded-up half of the period.
    assign low_len = (nxt_n >> 1) + NW'(nxt_n[0]);

    always_ff @(posedge clk) begin
        if (rst) pclk_q <= 1'b0;
        else     pclk_q <= !nxt_byp && (nxt_cnt >= low_len);
    end

    // R1: the square wave starts low after reset
    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !pclk_q);
endmodule

// File: rtl/pixclk_div.sv
module pixclk_div #(
    parameter int unsigned LO_W = 5,
    parameter int unsigned HI_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_bypass,
    input  logic [LO_W-1:0] cfg_div_lo,
    input  logic [HI_W-1:0] cfg_div_hi,
    output logic            pix_en,
    output logic            pix_clk
);
    localparam int unsigned NW = pixclk_pkg::div_width(LO_W, HI_W);

    logic          dec_byp;
    logic [NW-1:0] dec_n;
    logic          wrap, cur_byp, nxt_byp;
    logic [NW-1:0] nxt_cnt, nxt_n;

    pixclk_decode #(.LO_W(LO_W), .HI_W(HI_W), .NW(NW)) u_dec (
        .byp_i (cfg_bypass),
        .lo_i  (cfg_div_lo),
        .hi_i  (cfg_div_hi),
        .byp_o (dec_byp),
        .n_o   (dec_n)
    );

    pixclk_counter #(.NW(NW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_byp (dec_byp),
        .load_n   (dec_n),
        .wrap     (wrap),
        .cur_byp  (cur_byp),
        .nxt_cnt  (nxt_cnt),
        .nxt_byp  (nxt_byp),
        .nxt_n    (nxt_n)
    );

    pixclk_phase #(.NW(NW)) u_ph (
        .clk     (clk),
        .rst     (rst),
        .nxt_cnt (nxt_cnt),
        .nxt_byp (nxt_byp),
        .nxt_n   (nxt_n),
        .pclk_q  (pix_clk)
    );

    assign pix_en = wrap && !rst;

    // R3: a divided period holds a single enable pulse
    p_en_single_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !cur_byp) |=> (!pix_en || cur_byp));

    // R4: the enable falls inside the high phase
    p_en_high_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_en && !cur_byp) |-> pix_clk);

    // R5: no square wave while bypassed
    p_byp_low_r5: assert property (@(posedge clk) disable iff (rst)
        cur_byp |-> !pix_clk);
endmodule

// File: tb/sim_pixclk_div.sv
module sim_pixclk_div;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 100000;

    typedef struct packed {
        logic        byp;
        logic [4:0]  lo;
        logic [4:0]  hi;
        logic [10:0] per;
        logic [10:0] hcnt;
    } vec_t;

    // {bypass, lo, hi, expected period, expected high cycles}
    localparam vec_t VECS [9] = '{
        '{1'b0, 5'd0,  5'd0,  11'd2,    11'd1},   // R6 smallest
        '{1'b0, 5'd1,  5'd0,  11'd3,    11'd1},   // odd
        '{1'b0, 5'd5,  5'd0,  11'd7,    11'd3},   // odd
        '{1'b0, 5'd30, 5'd0,  11'd32,   11'd16},  // even
        '{1'b0, 5'd0,  5'd1,  11'd34,   11'd17},  // R2 high field
        '{1'b0, 5'd3,  5'd2,  11'd69,   11'd34},  // R2 both fields
        '{1'b1, 5'd7,  5'd3,  11'd1,    11'd0},   // R5
        '{1'b1, 5'd31, 5'd31, 11'd1,    11'd0},   // R5 other fields
        '{1'b0, 5'd31, 5'd31, 11'd1025, 11'd512}  // R6 largest
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byp = 1'b0;
    logic [4:0] lo  = 5'd0;
    logic [4:0] hi  = 5'd0;
    logic       en, pclk;
    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    pixclk_div u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_bypass (byp),
        .cfg_div_lo (lo),
        .cfg_div_hi (hi),
        .pix_en     (en),
        .pix_clk    (pclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts cycles up to and including the next enable.
    task automatic measure(output int per, output int hc);
        per = 0;
        hc  = 0;
        do begin
            @(negedge clk);
            per++;
            hc += int'(pclk);
        end while (!en);
    endtask

    task automatic reset_run(input string tag);
        int per, hc;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({tag, " R1 en low in reset"}, int'(en), 0);
        check({tag, " R1 clk low in reset"}, int'(pclk), 0);
        rst = 1'b0;
        #1;
        per = 1;
        hc  = int'(pclk);
        while (!en) begin
            @(negedge clk);
            per++;
            hc += int'(pclk);
        end
        check({tag, " R1 first period"}, per, 4);
        check({tag, " R1 first high"}, hc, 2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > MAX_CYC) begin
                bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, MAX_CYC);
                $display("test done: total=%0d bad=%0d", total + 1, bad);
                $finish;
            end
        end
    end

    initial begin
        int per, hc;
        lo = 5'd2;  // N = 4
        reset_run("initial");

        // Table walk: settings applied in the last cycle of a period
        for (int i = 0; i < 9; i++) begin
            byp = VECS[i].byp;
            lo  = VECS[i].lo;
            hi  = VECS[i].hi;
            measure(per, hc);
            check($sformatf("R3 vec%0d period", i), per, int'(VECS[i].per));
            check($sformatf("R4 vec%0d high", i), hc, int'(VECS[i].hcnt));
        end

        // R7: change partway through a period of 10
        byp = 1'b0; lo = 5'd8; hi = 5'd0;
        measure(per, hc);
        check("R7 setup period", per, 10);
        per = 0; hc = 0;
        repeat (3) begin
            @(negedge clk);
            per++;
            hc += int'(pclk);
        end
        lo = 5'd0;
        while (!en) begin
            @(negedge clk);
            per++;
            hc += int'(pclk);
        end
        check("R7 old period completes", per, 10);
        check("R7 old high phase", hc, 5);
        measure(per, hc);
        check("R7 new period", per, 2);

        // R7/R5: bypass requested mid-period is deferred
        lo = 5'd8;
        measure(per, hc);
        per = 0; hc = 0;
        repeat (4) begin
            @(negedge clk);
            per++;
        end
        byp = 1'b1;
        while (!en) begin
            @(negedge clk);
            per++;
        end
        check("R7 bypass deferred", per, 10);
        measure(per, hc);
        check("R5 bypass period", per, 1);
        check("R5 bypass clk low", hc, 0);

        // R1: reset in the middle of a period
        byp = 1'b0; lo = 5'd20;
        measure(per, hc);
        repeat (5) @(negedge clk);
        lo = 5'd2;
        reset_run("midrun");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule